// File: doc/BRIEF.md
# Divider Configuration Loader

This block holds the configuration word of a clock synthesizer: a 9-bit feedback divide value, a 2-bit output divide code and a 2-bit test select. It accepts the word in two ways. A parallel bus with an active-low load strobe can drive the values directly. A three-wire serial port, made of data, serial clock and serial load, fills a shift register and then moves its contents across. All inputs are asynchronous to the core clock. They pass through a synchronizer. The strobes and the serial clock then go through edge detectors, so every load action happens on one core clock edge.

While the parallel strobe is low the registers follow the bus. The rising edge of the strobe freezes them, and they stay frozen until the strobe falls again or a serial transfer happens. With the strobe high, serial clock edges shift data in. A rising serial load transfers the frame to the registers. While serial load stays high, every shifted bit updates the registers at once. A flag reports whether the held values came from the serial path. Reset clears only the sampling state and the shift register. It never changes the held configuration.

Top module: `dcfg_loader`

## Requirements
- R1: While the synchronized parallel strobe is low, m_o and n_o follow par_m_i and par_n_i, t_o reads 0 and ser_mode_o reads 0.
- R2: On the rising edge of the parallel strobe, the bus value present at that edge is captured. It is held while the bus changes and the strobe stays high.
- R3: With the parallel strobe high, each rising serial clock edge shifts ser_data_i into a 14-bit frame. The first bit sent lands highest. In the frame order, the fields are test select (2 bits, upper bit first), one discarded pad bit, output divide code (upper bit first), then feedback divide value from bit 8 down to bit 0.
- R4: A rising edge of ser_load_i with the parallel strobe high copies the frame fields of R3 to t_o, n_o and m_o, and sets ser_mode_o to 1. The pad bit reaches no output.
- R5: A falling edge of ser_load_i leaves m_o, n_o, t_o and ser_mode_o unchanged.
- R6: While ser_load_i is held high with the parallel strobe high, every rising serial clock edge shifts one bit and places the updated frame fields on the outputs.
- R7: With the parallel strobe high, ser_load_i low and no serial clock edge, activity on the parallel bus and on ser_data_i leaves all outputs unchanged.
- R8: A serial transfer replaces values latched from the parallel bus. A later low parallel strobe returns the outputs to the bus.
- R9: Asserting rst_n low leaves m_o, n_o, t_o and ser_mode_o unchanged, and clears the shift register to all zeros.
- R10: When the parallel strobe rise and the serial load rise fall on the same core clock cycle, the parallel capture takes effect: ser_mode_o is 0 and t_o is 0.

Top module port order follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset of the sampling state and the shift register |
| par_load_n_i | input | 1 | Active-low parallel load strobe |
| par_m_i | input | 9 | Parallel feedback divide value |
| par_n_i | input | 2 | Parallel output divide code |
| ser_clk_i | input | 1 | Serial shift clock, sampled by clk |
| ser_data_i | input | 1 | Serial data bit |
| ser_load_i | input | 1 | Serial transfer strobe |
| m_o | output | 9 | Held feedback divide value |
| n_o | output | 2 | Held output divide code |
| t_o | output | 2 | Held test select |
| ser_mode_o | output | 1 | 1 when the held values came from the serial path |

## Verification
The parallel strobe rising edge and the serial load rising edge can arrive in the same core clock cycle. The bench provokes this by driving both inputs on one falling clock edge, so the synchronizer delivers both edges together. Before that, the shift register is filled with a nonzero frame, so a wrong winner would show a different divide value and a raised mode flag. The bench judges the outcome on the held bus value, the zero test select and the low mode flag. It checks again after serial load falls, to confirm that the falling edge did not disturb the held values.

// File: rtl/dcfg_pkg.sv
package dcfg_pkg;

   typedef enum logic [1:0] {
      ACT_HOLD = 2'd0,
      ACT_PAR  = 2'd1,
      ACT_SER  = 2'd2
   } dcfg_act_e;

endpackage

// File: rtl/dcfg_sync.sv
module dcfg_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q,
   output logic         primed
);
   localparam int CNT_W = $clog2(STAGES + 2);
   localparam logic [CNT_W-1:0] PRIME_CNT = CNT_W'(STAGES + 1);

   logic [CNT_W-1:0] cnt;

   generate
      if (W < 1) begin : g_bad_w
         $error("dcfg_sync: W must be at least 1");
      end
      if (STAGES < 0) begin : g_bad_stages
         $error("dcfg_sync: STAGES must not be negative");
      end

      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [W-1:0] stg [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) stg[i] <= '0;
            end else begin
               stg[0] <= d;
               for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
            end
         end
         assign q = stg[STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                cnt <= '0;
      else if (cnt != PRIME_CNT) cnt <= cnt + 1'b1;
   end

   assign primed = (cnt == PRIME_CNT);

endmodule

// File: rtl/dcfg_edge.sv
module dcfg_edge #(
   parameter int W = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] cur,
   output logic [W-1:0] rise
);
   logic [W-1:0] prev;

   generate
      if (W < 1) begin : g_bad_w
         $error("dcfg_edge: W must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= '0;
      else        prev <= cur;
   end

   assign rise = cur & ~prev;

endmodule

// File: rtl/dcfg_shift.sv
module dcfg_shift #(
   parameter int M_W    = 9,
   parameter int N_W    = 2,
   parameter int T_W    = 2,
   parameter int PAD_W  = 1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           en,
   input  logic           din,
   output logic [M_W-1:0] m_nx,
   output logic [N_W-1:0] n_nx,
   output logic [T_W-1:0] t_nx
);
   localparam int FRAME_W = T_W + PAD_W + N_W + M_W;
   localparam int M_LSB   = 0;
   localparam int N_LSB   = M_W;
   localparam int T_LSB   = M_W + N_W + PAD_W;

   logic [FRAME_W-1:0] sr;
   logic [FRAME_W-1:0] sr_nx;

   generate
      if (FRAME_W < 2) begin : g_bad_frame
         $error("dcfg_shift: frame must hold at least two bits");
      end
   endgenerate

   assign sr_nx = en ? {sr[FRAME_W-2:0], din} : sr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sr <= '0;
      else        sr <= sr_nx;
   end

   assign m_nx = sr_nx[M_LSB +: M_W];
   assign n_nx = sr_nx[N_LSB +: N_W];
   assign t_nx = sr_nx[T_LSB +: T_W];

endmodule

// File: rtl/dcfg_regs.sv
module dcfg_regs
   import dcfg_pkg::*;
#(
   parameter int M_W = 9,
   parameter int N_W = 2,
   parameter int T_W = 2
) (
   input  logic           clk,
   input  dcfg_act_e      act,
   input  logic [M_W-1:0] par_m,
   input  logic [N_W-1:0] par_n,
   input  logic [M_W-1:0] ser_m,
   input  logic [N_W-1:0] ser_n,
   input  logic [T_W-1:0] ser_t,
   output logic [M_W-1:0] m_q,
   output logic [N_W-1:0] n_q,
   output logic [T_W-1:0] t_q,
   output logic           ser_q
);
   always_ff @(posedge clk) begin
      unique case (act)
         ACT_PAR: begin
            m_q   <= par_m;
            n_q   <= par_n;
            t_q   <= '0;
            ser_q <= 1'b0;
         end
         ACT_SER: begin
            m_q   <= ser_m;
            n_q   <= ser_n;
            t_q   <= ser_t;
            ser_q <= 1'b1;
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/dcfg_loader.sv
module dcfg_loader
   import dcfg_pkg::*;
#(
   parameter int M_W         = 9,
   parameter int N_W         = 2,
   parameter int T_W         = 2,
   parameter int PAD_W       = 1,
   parameter int SYNC_STAGES = 2
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           par_load_n_i,
   input  logic [M_W-1:0] par_m_i,
   input  logic [N_W-1:0] par_n_i,
   input  logic           ser_clk_i,
   input  logic           ser_data_i,
   input  logic           ser_load_i,
   output logic [M_W-1:0] m_o,
   output logic [N_W-1:0] n_o,
   output logic [T_W-1:0] t_o,
   output logic           ser_mode_o
);
   localparam int SYNC_W = 4 + N_W + M_W;
   localparam int EDGE_W = 3;

   generate
      if (M_W < 1 || N_W < 1 || T_W < 1) begin : g_bad_fields
         $error("dcfg_loader: field widths must be at least 1");
      end
      if (PAD_W < 0) begin : g_bad_pad
         $error("dcfg_loader: PAD_W must not be negative");
      end
   endgenerate

   logic [SYNC_W-1:0] raw;
   logic [SYNC_W-1:0] smp;
   logic              sync_ok;
   logic              pl_s, sl_s, sck_s, sd_s;
   logic [N_W-1:0]    n_s;
   logic [M_W-1:0]    m_s;
   logic [EDGE_W-1:0] rises;
   logic              pl_rise, sl_rise, sck_rise;
   logic              shift_en;
   dcfg_act_e         act;
   logic [M_W-1:0]    ser_m;
   logic [N_W-1:0]    ser_n;
   logic [T_W-1:0]    ser_t;

   assign raw = {par_load_n_i, ser_load_i, ser_clk_i, ser_data_i, par_n_i, par_m_i};

   dcfg_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .d      (raw),
      .q      (smp),
      .primed (sync_ok)
   );

   assign {pl_s, sl_s, sck_s, sd_s, n_s, m_s} = smp;

   dcfg_edge #(.W(EDGE_W)) u_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .cur   ({pl_s, sl_s, sck_s}),
      .rise  (rises)
   );

   assign {pl_rise, sl_rise, sck_rise} = rises;

   assign shift_en = sync_ok && pl_s && sck_rise;

   always_comb begin
      act = ACT_HOLD;
      if (sync_ok) begin
         if (!pl_s || pl_rise)                 act = ACT_PAR;
         else if (sl_rise || (sl_s && sck_rise)) act = ACT_SER;
      end
   end

   dcfg_shift #(.M_W(M_W), .N_W(N_W), .T_W(T_W), .PAD_W(PAD_W)) u_shift (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (shift_en),
      .din   (sd_s),
      .m_nx  (ser_m),
      .n_nx  (ser_n),
      .t_nx  (ser_t)
   );

   dcfg_regs #(.M_W(M_W), .N_W(N_W), .T_W(T_W)) u_regs (
      .clk   (clk),
      .act   (act),
      .par_m (m_s),
      .par_n (n_s),
      .ser_m (ser_m),
      .ser_n (ser_n),
      .ser_t (ser_t),
      .m_q   (m_o),
      .n_q   (n_o),
      .t_q   (t_o),
      .ser_q (ser_mode_o)
   );

endmodule

// File: rtl/dcfg_loader_chk.sv
module dcfg_loader_chk #(
   parameter int M_W = 9,
   parameter int N_W = 2,
   parameter int T_W = 2
) (
   input logic           clk,
   input logic           rst_n,
   input logic           sync_ok,
   input logic           pl_s,
   input logic           sl_s,
   input logic [M_W-1:0] m_s,
   input logic [N_W-1:0] n_s,
   input logic [M_W-1:0] m_o,
   input logic [N_W-1:0] n_o,
   input logic [T_W-1:0] t_o,
   input logic           ser_mode_o
);
   logic armed = 1'b0;

   always_ff @(posedge clk) begin
      if (sync_ok) armed <= 1'b1;
   end

   // R1
   par_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_ok && !pl_s) |=> (m_o == $past(m_s) && n_o == $past(n_s)));

   // R1
   par_tsel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_ok && !pl_s) |=> (t_o == '0 && !ser_mode_o));

   // R7
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_ok && pl_s && $past(pl_s) && !sl_s)
      |=> ($stable(m_o) && $stable(n_o) && $stable(t_o) && $stable(ser_mode_o)));

   // R4
   ser_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_ok && pl_s && $past(pl_s) && sl_s && !$past(sl_s)) |=> ser_mode_o);

   // R10
   pl_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_ok && pl_s && !$past(pl_s)) |=> (!ser_mode_o && t_o == '0));

   // R9
   rst_keep_chk: assert property (@(posedge clk)
      (armed && !sync_ok)
      |=> ($stable(m_o) && $stable(n_o) && $stable(t_o) && $stable(ser_mode_o)));

endmodule

bind dcfg_loader dcfg_loader_chk #(.M_W(M_W), .N_W(N_W), .T_W(T_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .sync_ok    (sync_ok),
   .pl_s       (pl_s),
   .sl_s       (sl_s),
   .m_s        (m_s),
   .n_s        (n_s),
   .m_o        (m_o),
   .n_o        (n_o),
   .t_o        (t_o),
   .ser_mode_o (ser_mode_o)
);

// File: tb/sim_dcfg_loader.sv
module sim_dcfg_loader;
   localparam int CLK_PERIOD = 10;
   localparam int SETTLE     = 8;
   localparam int HALF_SCK   = 4;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       par_load_n_i;
   logic [8:0] par_m_i;
   logic [1:0] par_n_i;
   logic       ser_clk_i;
   logic       ser_data_i;
   logic       ser_load_i;
   logic [8:0] m_o;
   logic [1:0] n_o;
   logic [1:0] t_o;
   logic       ser_mode_o;

   int vectors = 0;
   int fails   = 0;
   bit done    = 1'b0;
   logic [13:0] shreg = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dcfg_loader u0 (
      .clk          (clk),
      .rst_n        (rst_n),
      .par_load_n_i (par_load_n_i),
      .par_m_i      (par_m_i),
      .par_n_i      (par_n_i),
      .ser_clk_i    (ser_clk_i),
      .ser_data_i   (ser_data_i),
      .ser_load_i   (ser_load_i),
      .m_o          (m_o),
      .n_o          (n_o),
      .t_o          (t_o),
      .ser_mode_o   (ser_mode_o)
   );

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string tag, input int got, input int exp);
      vectors++;
      if (got != exp) begin
         fails++;
         $display("FAIL %s got %0d expected %0d", tag, got, exp);
      end
   endtask

   task automatic chk_cfg(input string tag, input int em, input int en,
                          input int et, input int emode);
      chk({tag, " m"}, int'(m_o), em);
      chk({tag, " n"}, int'(n_o), en);
      chk({tag, " t"}, int'(t_o), et);
      chk({tag, " mode"}, int'(ser_mode_o), emode);
   endtask

   task automatic ser_bit(input logic b);
      ser_data_i = b;
      wait_n(HALF_SCK);
      ser_clk_i = 1'b1;
      shreg = {shreg[12:0], b};
      wait_n(HALF_SCK);
      ser_clk_i = 1'b0;
      wait_n(HALF_SCK);
   endtask

   task automatic send_frame(input logic [1:0] t, input logic [1:0] n,
                             input logic [8:0] m, input logic pad);
      logic [13:0] bits;
      bits = {t, pad, n, m};
      for (int i = 13; i >= 0; i--) ser_bit(bits[i]);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      rst_n        = 1'b0;
      par_load_n_i = 1'b0;
      par_m_i      = 9'd25;
      par_n_i      = 2'd1;
      ser_clk_i    = 1'b0;
      ser_data_i   = 1'b0;
      ser_load_i   = 1'b0;
      wait_n(5);
      rst_n = 1'b1;
      wait_n(10);
      // R1: reset state with the strobe low follows the bus
      chk_cfg("R1 reset state", 25, 1, 0, 0);

      // R1 / R2: parallel sweep
      for (int i = 0; i <= 16; i++) begin
         for (int nv = 0; nv < 4; nv++) begin
            int mv;
            mv = (i == 16) ? 511 : i * 31;
            par_load_n_i = 1'b0;
            par_m_i = 9'(mv);
            par_n_i = 2'(nv);
            wait_n(SETTLE);
            chk_cfg("R1 transparent", mv, nv, 0, 0);
            par_load_n_i = 1'b1;
            wait_n(SETTLE);
            par_m_i = ~9'(mv);
            par_n_i = ~2'(nv);
            wait_n(SETTLE);
            chk_cfg("R2 held", mv, nv, 0, 0);
         end
      end

      // R3 / R4 / R5 / R8: serial sweep over a latched parallel value
      for (int k = 0; k < 12; k++) begin
         int tv, nv, mv, pv;
         tv = k % 4;
         nv = (k * 3) % 4;
         mv = (k == 11) ? 511 : (k * 43 + 5) % 512;
         pv = k % 2;
         par_load_n_i = 1'b0;
         par_m_i = 9'd100;
         par_n_i = 2'd2;
         wait_n(SETTLE);
         par_load_n_i = 1'b1;
         wait_n(SETTLE);
         send_frame(2'(tv), 2'(nv), 9'(mv), 1'(pv));
         chk_cfg("R3 no change before load", 100, 2, 0, 0);
         ser_load_i = 1'b1;
         wait_n(SETTLE);
         chk_cfg("R4 R8 transfer", mv, nv, tv, 1);
         ser_load_i = 1'b0;
         wait_n(SETTLE);
         chk_cfg("R5 fall keeps", mv, nv, tv, 1);
      end

      // R8: strobe low returns to the bus
      par_load_n_i = 1'b0;
      par_m_i = 9'd321;
      par_n_i = 2'd3;
      wait_n(SETTLE);
      chk_cfg("R8 back to bus", 321, 3, 0, 0);
      par_load_n_i = 1'b1;
      wait_n(SETTLE);

      // R6: pass-through with serial load held high
      ser_load_i = 1'b1;
      wait_n(SETTLE);
      chk_cfg("R6 entry", int'(shreg[8:0]), int'(shreg[10:9]), int'(shreg[13:12]), 1);
      for (int b = 0; b < 9; b++) begin
         ser_bit(1'((b * 5 + 1) % 3 == 0));
         chk_cfg("R6 pass", int'(shreg[8:0]), int'(shreg[10:9]), int'(shreg[13:12]), 1);
      end
      ser_load_i = 1'b0;
      wait_n(SETTLE);

      // R7: idle serial mode ignores bus and data activity
      send_frame(2'd2, 2'd1, 9'd77, 1'b1);
      ser_load_i = 1'b1;
      wait_n(SETTLE);
      ser_load_i = 1'b0;
      wait_n(SETTLE);
      for (int j = 0; j < 6; j++) begin
         par_m_i = 9'(j * 90);
         par_n_i = 2'(j);
         ser_data_i = j[0];
         wait_n(3);
      end
      chk_cfg("R7 idle", 77, 1, 2, 1);

      // R9: reset keeps values and clears the shift register
      send_frame(2'd3, 2'd3, 9'd300, 1'b0);
      rst_n = 1'b0;
      par_m_i = 9'd5;
      wait_n(5);
      rst_n = 1'b1;
      shreg = '0;
      wait_n(10);
      chk_cfg("R9 reset keeps", 77, 1, 2, 1);
      ser_load_i = 1'b1;
      wait_n(SETTLE);
      chk_cfg("R9 cleared frame", 0, 0, 0, 1);
      ser_load_i = 1'b0;
      wait_n(SETTLE);

      // R10: both strobes rise in the same cycle
      send_frame(2'd1, 2'd2, 9'd400, 1'b1);
      par_load_n_i = 1'b0;
      par_m_i = 9'd150;
      par_n_i = 2'd1;
      wait_n(SETTLE);
      par_load_n_i = 1'b1;
      ser_load_i = 1'b1;
      wait_n(SETTLE);
      chk_cfg("R10 parallel wins", 150, 1, 0, 0);
      ser_load_i = 1'b0;
      wait_n(SETTLE);
      chk_cfg("R10 R5 after fall", 150, 1, 0, 0);

      finish_run();
   end

endmodule